// File: doc/BRIEF.md
# In-flight branch outcome mimicker

This block keeps a circular record of conditional branches that have been fetched but not yet retired. Each record names the predictor entry that produced the branch's prediction (a table number and an index) and the direction the branch is currently believed to take. The predictor tables are updated only when a branch retires. Until then, a second fetch that lands on the same predictor entry would see a stale value. This block closes that gap. A combinational lookup searches every in-flight record for the entry identifier. When a record matches, the block returns that record's direction so that it can replace the table's prediction.

Four ports drive the block. A fetch port writes a new record at the head and reports the slot number it used. A lookup port searches by entry identifier. A resolve port reports a misprediction on a named slot: the head moves back to just past that slot, and the slot's direction is replaced by the real outcome. A retire port frees the oldest record. Records younger than a mispredicted slot are dropped at once, because they were fetched down the wrong path.

Top module: `inflight_update_mimicker`

## Requirements
- R1: After reset the buffer is empty: `stall` is 0, `push_slot` is 0 and no lookup hits.
- R2: A push accepted while not stalled writes its table number, index and direction into slot `push_slot`. `push_slot` then advances by one and wraps modulo the depth.
- R3: A lookup hits only when a live slot holds exactly the same table number and index. On a hit, `lk_dir` is that slot's stored direction (1 = taken). The lookup is combinational and sees the state as of the last clock edge.
- R4: When several live slots match, the youngest one (the one nearest the head) supplies `lk_dir`.
- R5: `stall` is 1 when the number of live slots is one less than the depth. A push while stalled is dropped: nothing is written and `push_slot` does not move.
- R6: A retire frees the oldest live slot, which no longer hits afterwards. A retire while empty has no effect.
- R7: A resolve on a live slot overwrites that slot's direction with `res_dir`. The head moves to the slot after it, so all younger slots stop hitting and the next push uses the slot after it.
- R8: When a valid resolve and a push arrive in the same cycle, the resolve wins and the push is dropped.
- R9: A resolve that names a slot outside the live range has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Fetch of a conditional branch |
| push_tbl | input | TBL_W | Providing table number |
| push_idx | input | IDX_W | Providing entry index |
| push_dir | input | 1 | Predicted direction, 1 = taken |
| push_slot | output | PW | Slot the next push will occupy |
| stall | output | 1 | Buffer full, pushes are dropped |
| lk_tbl | input | TBL_W | Lookup table number |
| lk_idx | input | IDX_W | Lookup entry index |
| lk_hit | output | 1 | A live slot matches |
| lk_dir | output | 1 | Direction of the youngest match |
| res_mispredict | input | 1 | Misprediction reported on `res_slot` |
| res_slot | input | PW | Slot of the mispredicted branch |
| res_dir | input | 1 | Actual outcome |
| ret_valid | input | 1 | Retire the oldest slot |

## Verification
The bench pushes the same entry identifier twice and checks that the younger direction wins. A design that searched oldest-first would return the stale outcome. It rewinds onto an older slot and checks that the younger records no longer hit. A design that only moved the head without gating validity would still hit on them. It also sends a resolve outside the live range, a retire on an empty buffer, and a push in the same cycle as a rewind, each of which must leave the state untouched. Finally it fills the buffer to one short of the depth, checks that the stall appears and the extra push is dropped, and then wraps the head past the last slot.

// File: rtl/inflight_update_mimicker.sv
module inflight_update_mimicker #(
  parameter int DEPTH = 64,
  parameter int TBL_W = 4,
  parameter int IDX_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid,
  input  logic [TBL_W-1:0]         push_tbl,
  input  logic [IDX_W-1:0]         push_idx,
  input  logic                     push_dir,
  output logic [$clog2(DEPTH)-1:0] push_slot,
  output logic                     stall,
  input  logic [TBL_W-1:0]         lk_tbl,
  input  logic [IDX_W-1:0]         lk_idx,
  output logic                     lk_hit,
  output logic                     lk_dir,
  input  logic                     res_mispredict,
  input  logic [$clog2(DEPTH)-1:0] res_slot,
  input  logic                     res_dir,
  input  logic                     ret_valid
);
  localparam int PW = $clog2(DEPTH);

  logic [TBL_W-1:0] tbl_q [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [DEPTH-1:0] dir_q;
  logic [PW-1:0]    head, tail;

  wire [PW-1:0] used      = head - tail;
  wire [PW-1:0] res_age   = res_slot - tail;
  wire          do_rewind = res_mispredict && (res_age < used);
  wire          do_push   = push_valid && !stall && !do_rewind;
  wire          do_retire = ret_valid && (used != '0);

  assign stall     = (PW'(head + 1'b1) == tail);
  assign push_slot = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (do_rewind)    head <= PW'(res_slot + 1'b1);
      else if (do_push) head <= PW'(head + 1'b1);
      if (do_retire)    tail <= PW'(tail + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      tbl_q[head] <= push_tbl;
      idx_q[head] <= push_idx;
      dir_q[head] <= push_dir;
    end else if (do_rewind) begin
      dir_q[res_slot] <= res_dir;
    end
  end

  always_comb begin
    logic [PW-1:0] s;
    lk_hit = 1'b0;
    lk_dir = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      s = PW'(tail + PW'(k));
      if (PW'(k) < used && tbl_q[s] == lk_tbl && idx_q[s] == lk_idx) begin
        lk_hit = 1'b1;
        lk_dir = dir_q[s];
      end
    end
  end
endmodule

module inflight_update_mimicker_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          res_mispredict,
  input logic [PW-1:0] res_slot,
  input logic          ret_valid,
  input logic          stall,
  input logic [PW-1:0] push_slot,
  input logic          lk_hit,
  input logic [PW-1:0] head,
  input logic [PW-1:0] tail
);
  wire [PW-1:0] live_n = head - tail;
  wire [PW-1:0] age    = res_slot - tail;
  wire          live   = age < live_n;

  a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !stall && !res_mispredict |=> push_slot == PW'($past(push_slot) + 1'b1));

  a_r5_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && stall && !res_mispredict |=> $stable(push_slot));

  a_r7_rewind_head: assert property (@(posedge clk) disable iff (!rst_n)
    res_mispredict && live |=> push_slot == PW'($past(res_slot) + 1'b1));

  a_r8_rewind_beats_push: assert property (@(posedge clk) disable iff (!rst_n)
    res_mispredict && live && push_valid |=> push_slot == PW'($past(res_slot) + 1'b1));

  a_r9_stale_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    res_mispredict && !live && !push_valid |=> $stable(push_slot));

  a_r6_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && (head != tail) |=> tail == PW'($past(tail) + 1'b1));

  a_r3_no_hit_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (head == tail) |-> !lk_hit);
endmodule

bind inflight_update_mimicker inflight_update_mimicker_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .res_mispredict(res_mispredict),
  .res_slot(res_slot), .ret_valid(ret_valid), .stall(stall), .push_slot(push_slot),
  .lk_hit(lk_hit), .head(head), .tail(tail)
);

// File: tb/tb_inflight_update_mimicker.sv
module tb_inflight_update_mimicker;
  localparam int PW = 6;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_dir = 0, lk_hit, lk_dir, stall;
  logic [3:0] push_tbl = 0, lk_tbl = 0;
  logic [14:0] push_idx = 0, lk_idx = 0;
  logic [PW-1:0] push_slot, res_slot = 0;
  logic res_mispredict = 0, res_dir = 0, ret_valid = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  inflight_update_mimicker dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_tbl(push_tbl),
    .push_idx(push_idx), .push_dir(push_dir), .push_slot(push_slot), .stall(stall),
    .lk_tbl(lk_tbl), .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_dir(lk_dir),
    .res_mispredict(res_mispredict), .res_slot(res_slot), .res_dir(res_dir),
    .ret_valid(ret_valid)
  );

  // op: 0 push, 1 lookup check, 2 retire, 3 resolve (slot in idx low bits)
  localparam int NV = 22;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 4'd1, 15'd100, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 slot0
    {2'd0, 4'd2, 15'd200, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 slot1
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    {2'd1, 4'd2, 15'd200, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    {2'd1, 4'd1, 15'd200, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 table differs
    {2'd0, 4'd1, 15'd100, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 slot2
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 youngest
    {2'd3, 4'd0, 15'd2,   1'b1, 1'b0, 1'b0, 4'd7},  // R7 fix slot2
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b1, 1'b1, 4'd7},  // R7
    {2'd3, 4'd0, 15'd0,   1'b0, 1'b0, 1'b0, 4'd7},  // R7 rewind slot0
    {2'd1, 4'd2, 15'd200, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 younger gone
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b1, 1'b0, 4'd7},  // R7
    {2'd2, 4'd0, 15'd0,   1'b0, 1'b0, 1'b0, 4'd6},  // R6 retire
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {2'd0, 4'd3, 15'd5,   1'b1, 1'b0, 1'b0, 4'd9},  // R9 slot1
    {2'd3, 4'd0, 15'd5,   1'b0, 1'b0, 1'b0, 4'd9},  // R9 stale slot5
    {2'd1, 4'd3, 15'd5,   1'b0, 1'b1, 1'b1, 4'd9},  // R9
    {2'd1, 4'd1, 15'd100, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    {2'd2, 4'd0, 15'd0,   1'b0, 1'b0, 1'b0, 4'd6},  // R6 now empty
    {2'd2, 4'd0, 15'd0,   1'b0, 1'b0, 1'b0, 4'd6},  // R6 retire on empty
    {2'd0, 4'd4, 15'd7,   1'b1, 1'b0, 1'b0, 4'd6},  // R6 slot2
    {2'd1, 4'd4, 15'd7,   1'b0, 1'b1, 1'b1, 4'd6}   // R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [3:0] t, input logic [14:0] i, input logic d);
    push_valid = 1; push_tbl = t; push_idx = i; push_dir = d;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic do_res(input logic [PW-1:0] s, input logic d);
    res_mispredict = 1; res_slot = s; res_dir = d;
    @(negedge clk);
    res_mispredict = 0;
  endtask

  task automatic do_ret();
    ret_valid = 1;
    @(negedge clk);
    ret_valid = 0;
  endtask

  task automatic look(input string req, input logic [3:0] t, input logic [14:0] i,
                      input logic eh, input logic ed);
    lk_tbl = t; lk_idx = i;
    #1;
    chk({req, " hit"}, int'(lk_hit), int'(eh));
    if (eh) chk({req, " dir"}, int'(lk_dir), int'(ed));
  endtask

  task automatic reset_dut();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    reset_dut();
    chk("R1 stall", int'(stall), 0);
    chk("R1 push_slot", int'(push_slot), 0);
    look("R1", 4'd1, 15'd100, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      string r;
      e = VEC[v];
      r = $sformatf("R%0d vec%0d", e[3:0], v);
      case (e[27:26])
        2'd0: do_push(e[25:22], e[21:7], e[6]);
        2'd1: look(r, e[25:22], e[21:7], e[5], e[4]);
        2'd2: do_ret();
        default: do_res(PW'(e[21:7]), e[6]);
      endcase
    end

    // R8: resolve and push in the same cycle
    reset_dut();
    do_push(4'd1, 15'd10, 1'b0);
    do_push(4'd1, 15'd11, 1'b0);
    push_valid = 1; push_tbl = 4'd1; push_idx = 15'd777; push_dir = 1;
    res_mispredict = 1; res_slot = 0; res_dir = 1;
    @(negedge clk);
    push_valid = 0; res_mispredict = 0;
    look("R8 dropped push", 4'd1, 15'd777, 1'b0, 1'b0);
    chk("R8 push_slot", int'(push_slot), 1);
    look("R8 corrected", 4'd1, 15'd10, 1'b1, 1'b1);

    // R5: fill to depth-1, then R2 wrap
    reset_dut();
    for (int k = 0; k < 63; k++) begin
      chk("R5 no stall yet", int'(stall), 0);
      do_push(4'd2, 15'(k), k[0]);
    end
    chk("R5 stall", int'(stall), 1);
    chk("R5 push_slot", int'(push_slot), 63);
    do_push(4'd2, 15'd999, 1'b1);
    chk("R5 push_slot held", int'(push_slot), 63);
    look("R5 dropped", 4'd2, 15'd999, 1'b0, 1'b0);
    look("R4 oldest live", 4'd2, 15'd0, 1'b1, 1'b0);
    look("R3 last", 4'd2, 15'd62, 1'b1, 1'b0);
    do_ret();
    chk("R5 stall cleared", int'(stall), 0);
    look("R6 retired", 4'd2, 15'd0, 1'b0, 1'b0);
    do_push(4'd2, 15'd500, 1'b1);
    chk("R2 wrap", int'(push_slot), 0);
    look("R2 wrapped entry", 4'd2, 15'd500, 1'b1, 1'b1);
    chk("R5 stall again", int'(stall), 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule